// File: doc/BRIEF.md
# Third-Order Sinc Decimator, Rate 16

This block is the first rate-reduction stage behind a single-bit sigma-delta modulator whose bit stream runs at 128 times the final audio rate. It applies a cubic sinc (three cascaded boxcar) low-pass response and keeps one result out of every 16 inputs. The output, at 8 times the audio rate, is handed to a chain of three half-band stages that each halve the rate, for an overall ratio of 128.

Each clock on which `en_i` is high takes one modulator bit. A one counts as +1 and a zero as -1. Three running sums advance at the input rate. On every 16th accepted bit, three first-difference stages with a one-sample delay produce a signed word. That word and a one-clock strobe appear on the next clock. One instance serves one channel, so a stereo design uses two of them.

Top module: `sinc3_decimator`

## Requirements
- R1: While `rst_ni` is low, and right after it is released, `data_o` is 0 and `valid_o` is 0. The input counter restarts from zero.
- R2: `valid_o` is high for exactly one clock. That clock directly follows the clock that accepted the 16th, 32nd, 48th, ... bit since reset. `valid_o` is low on all other clocks.
- R3: When `valid_o` is high, `data_o` (two's complement, 14 bits) equals the sum over the last 46 accepted samples of h[j]·x, where x is +1 for a one and -1 for a zero. Samples before reset count as 0. h[j] is the number of ways to write j as a+b+c with each term in 0..15, and j = 0 is the newest sample.
- R4: A run of ones gives +4096 from the third strobe on. A run of zeros gives -4096 once 46 zeros have been accepted.
- R5: On clocks with `en_i` low, `bit_i` is ignored, no strobe is produced, and the filter state does not advance.
- R6: `data_o` keeps its value on every clock where `valid_o` is low.
- R7: An alternating 1,0,1,0,... input gives 0 once the window holds only that pattern.
- R8: Results stay exact over arbitrarily long runs, even though the internal sums wrap around modulo 2^14.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Accept `bit_i` on this clock |
| bit_i | input | 1 | Modulator bit: 1 means +1, 0 means -1 |
| data_o | output | 14 | Signed filtered sample, range -4096..+4096 |
| valid_o | output | 1 | One-clock strobe marking a new `data_o` |

## Verification
The properties assume that `en_i` and `bit_i` are known after reset and change only away from the rising edge. The result-range property also assumes that the bit stream started from the reset state, so that the window truly holds at most 46 samples. The bench changes inputs only on the falling edge and always drives defined values. It starts every sequence with a reset, including one applied partway through a group of 16. It mixes back-to-back enables with idle clocks on which `bit_i` toggles freely.

// File: rtl/sinc3_pkg.sv
package sinc3_pkg;
  // growth of an N-th order sinc filter plus sign plus headroom for exact full scale
  function automatic int acc_width(input int order, input int rate);
    return 2 + order * $clog2(rate);
  endfunction

  function automatic int full_scale(input int order, input int rate);
    int v;
    v = 1;
    for (int i = 0; i < order; i++) v = v * rate;
    return v;
  endfunction
endpackage

// File: rtl/sinc3_integ.sv
module sinc3_integ #(
  parameter int ORDER = 3,
  parameter int W     = 14
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                en_i,
  input  logic signed [W-1:0] x_i,
  output logic signed [W-1:0] sum_o
);
  logic signed [W-1:0] chain [ORDER+1];
  assign chain[0] = x_i;

  for (genvar g = 0; g < ORDER; g++) begin : g_stage
    logic signed [W-1:0] acc_q;
    assign chain[g+1] = acc_q + chain[g];
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)   acc_q <= '0;
      else if (en_i) acc_q <= chain[g+1];
    end
  end

  // post-update value of last stage, includes current sample
  assign sum_o = chain[ORDER];
endmodule

// File: rtl/sinc3_phase.sv
module sinc3_phase #(
  parameter int RATE = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  output logic dump_o
);
  localparam int CW = (RATE > 1) ? $clog2(RATE) : 1;
  localparam logic [CW-1:0] LAST = CW'(RATE - 1);

  logic [CW-1:0] cnt_q;

  assign dump_o = en_i && (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (dump_o) cnt_q <= '0;
    else if (en_i)   cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/sinc3_comb.sv
module sinc3_comb #(
  parameter int ORDER = 3,
  parameter int W     = 14
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                ld_i,
  input  logic signed [W-1:0] din_i,
  output logic signed [W-1:0] data_o,
  output logic                valid_o
);
  logic signed [W-1:0] chain [ORDER+1];
  assign chain[0] = din_i;

  for (genvar g = 0; g < ORDER; g++) begin : g_stage
    logic signed [W-1:0] dly_q;
    assign chain[g+1] = chain[g] - dly_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)   dly_q <= '0;
      else if (ld_i) dly_q <= chain[g];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_o  <= '0;
      valid_o <= 1'b0;
    end else begin
      valid_o <= ld_i;
      if (ld_i) data_o <= chain[ORDER];
    end
  end
endmodule

// File: rtl/sinc3_decimator.sv
module sinc3_decimator #(
  parameter int RATE  = 16,
  parameter int ORDER = 3,
  localparam int ACC_W = sinc3_pkg::acc_width(ORDER, RATE)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             bit_i,
  output logic [ACC_W-1:0] data_o,
  output logic             valid_o
);
  logic signed [ACC_W-1:0] x_s;
  logic signed [ACC_W-1:0] integ_sum;
  logic signed [ACC_W-1:0] comb_out;
  logic                    dump;

  assign x_s = bit_i ? ACC_W'(1) : '1;

  sinc3_integ #(.ORDER(ORDER), .W(ACC_W)) u_integ (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (en_i),
    .x_i    (x_s),
    .sum_o  (integ_sum)
  );

  sinc3_phase #(.RATE(RATE)) u_phase (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (en_i),
    .dump_o (dump)
  );

  sinc3_comb #(.ORDER(ORDER), .W(ACC_W)) u_comb (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .ld_i    (dump),
    .din_i   (integ_sum),
    .data_o  (comb_out),
    .valid_o (valid_o)
  );

  assign data_o = comb_out;
endmodule

// File: rtl/sinc3_decimator_chk.sv
module sinc3_decimator_chk #(
  parameter int RATE  = 16,
  parameter int ORDER = 3,
  parameter int W     = 14
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         en_i,
  input logic         bit_i,
  input logic [W-1:0] data_o,
  input logic         valid_o
);
  localparam int FS = sinc3_pkg::full_scale(ORDER, RATE);

  AST_RESET_QUIET: assert property (@(posedge clk_i) !rst_ni |-> !valid_o); // R1
  AST_STROBE_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> !valid_o); // R2
  AST_STROBE_AFTER_EN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> $past(en_i)); // R2
  AST_IDLE_NO_STROBE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> !valid_o); // R5
  AST_HOLD_BETWEEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> $stable(data_o)); // R6
  AST_IN_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($signed(data_o) <= FS) && ($signed(data_o) >= -FS)); // R3
endmodule

bind sinc3_decimator sinc3_decimator_chk #(.RATE(RATE), .ORDER(ORDER), .W(ACC_W)) u_chk (.*);

// File: tb/tb_sinc3_decimator.sv
`timescale 1ns/1ps
module tb_sinc3_decimator;
  localparam int RATE  = 16;
  localparam int ORDER = 3;
  localparam int W     = 14;
  localparam int TAPS  = ORDER * (RATE - 1) + 1;
  localparam int NTBL  = 14;
  // {idle-gap flag, 16 bits fed MSB first}
  localparam logic [16:0] TBL [NTBL] = '{
    17'h0ffff, 17'h0ffff, 17'h1ffff, 17'h0ffff,
    17'h00000, 17'h10000, 17'h00000,
    17'h0aaaa, 17'h1aaaa, 17'h0aaaa,
    17'h01234, 17'h1f0f0, 17'h08001, 17'h17ffe
  };

  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic         en_i = 1'b0;
  logic         bit_i = 1'b0;
  logic [W-1:0] data_o;
  logic         valid_o;

  always #2 clk_i = ~clk_i;

  sinc3_decimator dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(en_i), .bit_i(bit_i),
    .data_o(data_o), .valid_o(valid_o)
  );

  int h [TAPS];
  int hist [TAPS];
  int n_en;
  int checks;
  int errors;
  logic [W-1:0] last_data;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int model();
    int s;
    s = 0;
    for (int j = 0; j < TAPS; j++) s += h[j] * hist[j];
    return s;
  endfunction

  task automatic clear_model();
    for (int j = 0; j < TAPS; j++) hist[j] = 0;
    n_en = 0;
    last_data = '0;
  endtask

  task automatic step(input logic en, input logic b, input string req);
    int exp;
    en_i  = en;
    bit_i = b;
    @(negedge clk_i);
    if (en) begin
      for (int j = TAPS - 1; j > 0; j--) hist[j] = hist[j-1];
      hist[0] = b ? 1 : -1;
      n_en++;
    end
    if (en && (n_en % RATE == 0)) begin
      exp = model();
      check(valid_o == 1'b1, "R2", int'(valid_o), 1);
      check($signed(data_o) == exp, req, int'($signed(data_o)), exp);
      last_data = data_o;
    end else begin
      check(valid_o == 1'b0, en ? "R2" : "R5", int'(valid_o), 0);
      check(data_o == last_data, "R6", int'($signed(data_o)), int'($signed(last_data)));
    end
  endtask

  task automatic do_reset();
    en_i = 1'b0;
    @(negedge clk_i);
    rst_ni = 1'b0;
    @(negedge clk_i);
    check(data_o == '0, "R1", int'($signed(data_o)), 0);
    check(valid_o == 1'b0, "R1", int'(valid_o), 0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    clear_model();
    @(negedge clk_i);
    check(data_o == '0 && valid_o == 1'b0, "R1", int'($signed(data_o)), 0);
  endtask

  initial begin
    #800000;
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [15:0] lfsr;
    checks = 0;
    errors = 0;
    for (int j = 0; j < TAPS; j++) h[j] = 0;
    for (int a = 0; a < RATE; a++)
      for (int b = 0; b < RATE; b++)
        for (int c = 0; c < RATE; c++) h[a+b+c]++;
    clear_model();

    // R1 reset state
    @(negedge clk_i);
    check(data_o == '0, "R1", int'($signed(data_o)), 0);
    check(valid_o == 1'b0, "R1", int'(valid_o), 0);
    do_reset();

    // table walk, R3 values, R5 gaps
    for (int e = 0; e < NTBL; e++) begin
      for (int k = 15; k >= 0; k--) begin
        step(1'b1, TBL[e][k], "R3");
        if (TBL[e][16]) step(1'b0, ~TBL[e][k], "R5");
      end
      if (e == 3) check($signed(data_o) == 4096, "R4", int'($signed(data_o)), 4096);
      if (e == 6) check($signed(data_o) == -4096, "R4", int'($signed(data_o)), -4096);
      if (e == 9) check($signed(data_o) == 0, "R7", int'($signed(data_o)), 0);
    end

    // R5 long idle stretch with toggling bit
    for (int i = 0; i < 25; i++) step(1'b0, i[0], "R5");

    // R1/R2 reset partway through a group, then phase restarts
    for (int i = 0; i < 7; i++) step(1'b1, 1'b1, "R3");
    do_reset();
    for (int i = 0; i < RATE; i++) step(1'b1, 1'b0, "R2");
    check(last_data == data_o && $signed(data_o) == h[0] * -1 * 0 + model(), "R2",
          int'($signed(data_o)), model());

    // R8 long pseudo-random run, sums wrap many times
    lfsr = 16'hace1;
    for (int i = 0; i < 60 * RATE; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      step(1'b1, lfsr[0], "R8");
      if (lfsr[3] && lfsr[7]) step(1'b0, lfsr[1], "R5");
    end
    for (int i = 0; i < 3 * RATE; i++) step(1'b1, 1'b1, "R8");
    check($signed(data_o) == 4096, "R8", int'($signed(data_o)), 4096);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule